// File: doc/BRIEF.md
# MDIO Command Bridge

This block lets software reach the management registers of an external Ethernet PHY through one 32-bit memory-mapped command word. A single store to the word both selects the operation and starts it. Bit 31 is the direction flag, bits 23:16 hold a register number and bits 15:0 carry the data. The bridge then sends a complete serial management frame on the MDC/MDIO pins to a PHY whose address is fixed by a parameter.

Completion is reported through bit 31, and its meaning depends on the direction. A write is started with the flag at 1; the flag reads 1 while the frame runs and drops to 0 when it is finished. A read is started with the flag at 0; the flag reads 0 while the frame runs and rises to 1 once bits 15:0 hold the value returned by the PHY. Software polls the word until the flag changes.

MDC runs only while a frame is in progress and is divided down from the system clock. With the default divider a 125 MHz clock gives 2.5 MHz, so one transaction takes about 26 µs. That is far inside a software polling budget of a few thousand polls spaced 100 µs apart.

Top module: `mdio_cmd_bridge`

## Requirements
- R1: After a synchronous reset the command word reads 0x00000000, MDC is low and the MDIO output enable is low.
- R2: A store with bit 31 = 1 starts a write frame with opcode 01 that carries bits 15:0 of the stored word as data. A store with bit 31 = 0 starts a read frame with opcode 10.
- R3: During a write the stored word reads back unchanged, with bit 31 at 1. When the frame ends, bit 31 reads 0 and every other bit keeps its stored value.
- R4: During a read bit 31 reads 0. When the frame ends, bit 31 reads 1, bits 15:0 hold the 16 bits the PHY returned, and bits 30:16 keep their stored value.
- R5: Each frame is 64 MDC periods, sent MSB first. It starts with 32 ones and the start pattern 01, followed by the 2-bit opcode, the 5-bit PHY address set by parameter `PHY_ADDR`, the 5-bit register number, 2 turnaround bits and 16 data bits.
- R6: Only bits 20:16 of the stored word form the register number in the frame, so register numbers 0, 1, 4 and 9 appear there unchanged. Bits 23:21 are kept and read back but never reach the pins.
- R7: One MDC period lasts 2*`HALF_DIV` system clocks (default 25, which gives 2.5 MHz at 125 MHz). MDC is low whenever no frame is in progress.
- R8: In a read frame the output enable is low from the first turnaround bit (bit 46) to the end of the frame. Incoming data is captured on the rising edge of MDC.
- R9: A store made while a transaction is still in progress is ignored. The word keeps its busy value and the frame in progress is not disturbed.
- R10: The flag changes to its completion value no more than 128*`HALF_DIV`+4 system clocks after the store that started the transaction.
- R11: In a write frame the bridge itself drives the turnaround bits as 1 then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Store strobe for the command word |
| cmd_wdata | input | 32 | Value stored into the command word |
| cmd_rdata | output | 32 | Current value of the command word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for mdio_o (low releases the line) |
| mdio_i | input | 1 | Serial data sampled from the PHY |

## Verification
The bench stores writes to the control, advertisement and gigabit-control register numbers and then reads back status and those same registers. A read only matches if the right frame reached the PHY model and the bridge captured the returned bits on the correct MDC edge. A store that sets bits 23:21 of the register field shows whether those bits leak into the frame or are lost from the readback. A second store placed in the middle of a running write shows whether a busy bridge accepts it: if it did, the PHY model would receive an extra frame and a later read of the targeted register would return the wrong value. The PHY model also watches the output enable during each read's turnaround and data bits, and it times every MDC period.

// File: rtl/mdio_bridge_pkg.sv
`timescale 1ns/1ps
package mdio_bridge_pkg;

    localparam int BIT_IDX_W = 6;
    localparam logic [BIT_IDX_W-1:0] PREAMBLE_END = 6'd31;
    localparam logic [BIT_IDX_W-1:0] TA_POS       = 6'd46;
    localparam logic [BIT_IDX_W-1:0] DATA_POS     = 6'd48;
    localparam logic [BIT_IDX_W-1:0] LAST_POS     = 6'd63;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef struct packed {
        logic        flag;
        logic [6:0]  spare;
        logic [7:0]  reg_addr;
        logic [15:0] data;
    } phy_cmd_t;

    function automatic logic [63:0] build_frame(
        input logic        is_wr,
        input logic [4:0]  phy,
        input logic [4:0]  regn,
        input logic [15:0] wdata
    );
        mdio_op_e op;
        op = is_wr ? OP_WRITE : OP_READ;
        return {32'hFFFF_FFFF, 2'b01, op, phy, regn,
                (is_wr ? 2'b10 : 2'b11),
                (is_wr ? wdata : 16'hFFFF)};
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
    parameter int HALF_DIV = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt;
    logic             terminal;

    assign terminal  = run && (cnt == CNT_LAST);
    assign rise_tick = terminal && !mdc;
    assign fall_tick = terminal && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (terminal) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !mdc);

endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine
    import mdio_bridge_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR = 5'd1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        start_wr,
    input  logic [4:0]  start_reg,
    input  logic [15:0] start_data,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        busy,
    output logic        op_wr,
    output logic        done,
    output logic [15:0] rdata,
    output logic        mdio_o,
    output logic        mdio_oe
);
    logic [BIT_IDX_W-1:0] bit_idx;
    logic [63:0]          shreg;

    assign mdio_o  = busy ? shreg[63] : 1'b1;
    assign mdio_oe = busy && (op_wr || (bit_idx < TA_POS));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            op_wr   <= 1'b0;
            bit_idx <= '0;
            shreg   <= '1;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy    <= 1'b1;
                op_wr   <= start_wr;
                bit_idx <= '0;
                shreg   <= build_frame(start_wr, PHY_ADDR, start_reg, start_data);
                rdata   <= '0;
            end else if (busy) begin
                if (rise_tick && !op_wr && (bit_idx >= DATA_POS))
                    rdata <= {rdata[14:0], mdio_i};
                if (fall_tick) begin
                    if (bit_idx == LAST_POS) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        shreg   <= {shreg[62:0], 1'b1};
                    end
                end
            end
        end
    end

    // R5
    preamble_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (bit_idx <= PREAMBLE_END)) |-> mdio_o);

    // R2
    start_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && (bit_idx == '0)));

    // R10
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

// File: rtl/mdio_cmd_bridge.sv
`timescale 1ns/1ps
module mdio_cmd_bridge
    import mdio_bridge_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR = 5'd1,
    parameter int         HALF_DIV = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_we,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    phy_cmd_t    cmd_q;
    phy_cmd_t    wcmd;
    logic        accept;
    logic        eng_busy;
    logic        eng_op_wr;
    logic        eng_done;
    logic [15:0] eng_rdata;
    logic        rise_tick;
    logic        fall_tick;

    assign wcmd      = phy_cmd_t'(cmd_wdata);
    assign accept    = cmd_we && !eng_busy && !eng_done;
    assign cmd_rdata = cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q <= wcmd;
        end else if (eng_done) begin
            cmd_q.flag <= !eng_op_wr;
            if (!eng_op_wr)
                cmd_q.data <= eng_rdata;
        end
    end

    mdio_clk_div #(
        .HALF_DIV (HALF_DIV)
    ) u_div (
        .clk       (clk),
        .rst       (rst),
        .run       (eng_busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine #(
        .PHY_ADDR (PHY_ADDR)
    ) u_eng (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .start_wr   (wcmd.flag),
        .start_reg  (wcmd.reg_addr[4:0]),
        .start_data (wcmd.data),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .mdio_i     (mdio_i),
        .busy       (eng_busy),
        .op_wr      (eng_op_wr),
        .done       (eng_done),
        .rdata      (eng_rdata),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );

    // R9
    busy_store_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && eng_busy) |=> $stable(cmd_q[30:16]));

    // R3
    wr_flag_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_busy && eng_op_wr) |-> cmd_q.flag);

    // R4
    rd_flag_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_busy && !eng_op_wr) |-> !cmd_q.flag);

    // R4
    rd_result_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_done && !eng_op_wr) |=> (cmd_q.flag && (cmd_q.data == $past(eng_rdata))));

endmodule

// File: tb/sim_mdio_cmd_bridge.sv
`timescale 1ns/1ps
module sim_mdio_cmd_bridge;
    localparam int         HALF  = 4;
    localparam logic [4:0] PHYA  = 5'h03;
    localparam int         LIMIT = 128*HALF + 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    wire  [31:0] cmd_rdata;
    wire         mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #4 clk = ~clk;

    mdio_cmd_bridge #(.PHY_ADDR(PHYA), .HALF_DIV(HALF)) u0 (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i));

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic [4:0]  regn;
        logic [15:0] data;
    } exp_frame_t;
    exp_frame_t exp_q[$];

    logic [15:0] phy_mem [32];
    logic [15:0] shadow  [32];
    logic [0:63] fb;
    int  pcnt = 0;
    int  oe_bad = 0, ta_seen = 0, per_bad = 0, per_seen = 0;
    longint cyc = 0;
    longint last_rise = -1;

    always @(posedge clk) cyc++;

    // PHY model and frame monitor: pops expected frames as they complete
    always @(posedge mdc) begin
        logic       line;
        logic       is_rd;
        logic [4:0] ra;
        int         nb;
        exp_frame_t e;
        line = mdio_oe ? mdio_o : mdio_i;
        fb[pcnt] = line;
        if (pcnt != 0) begin
            per_seen++;
            if (cyc - last_rise != 2*HALF) per_bad++;
        end
        last_rise = cyc;
        is_rd = (pcnt >= 35) && (fb[34:35] == 2'b10);
        ra = fb[41:45];
        if (is_rd && pcnt >= 46) begin
            ta_seen++;
            if (mdio_oe) oe_bad++;
        end
        nb = pcnt + 1;
        if (is_rd && pcnt >= 45 && nb >= 48 && nb <= 63) mdio_i = phy_mem[ra][63-nb];
        else if (is_rd && nb == 47) mdio_i = 1'b0;
        else mdio_i = 1'b1;
        if (pcnt == 63) begin
            pcnt = 0;
            if (exp_q.size() == 0) begin
                check(0, "R9", "unexpected frame", {16'h0, fb[48:63]}, 32'h0);
            end else begin
                e = exp_q.pop_front();
                check(fb[0:31] == 32'hFFFF_FFFF && fb[32:33] == 2'b01, "R5",
                      "preamble/start", {30'h0, fb[32:33]}, 32'h1);
                check(fb[34:35] == (e.wr ? 2'b01 : 2'b10), "R2", "opcode",
                      {30'h0, fb[34:35]}, e.wr ? 32'h1 : 32'h2);
                check(fb[36:40] == PHYA, "R5", "phy address",
                      {27'h0, fb[36:40]}, {27'h0, PHYA});
                check(fb[41:45] == e.regn, "R6", "register number",
                      {27'h0, fb[41:45]}, {27'h0, e.regn});
                if (e.wr)
                    check(fb[46:47] == 2'b10, "R11", "write turnaround",
                          {30'h0, fb[46:47]}, 32'h2);
                check(fb[48:63] == e.data, e.wr ? "R2" : "R8", "frame data",
                      {16'h0, fb[48:63]}, {16'h0, e.data});
                if (fb[34:35] == 2'b01) phy_mem[fb[41:45]] = fb[48:63];
            end
        end else begin
            pcnt++;
        end
    end

    task automatic run_cmd(input logic [31:0] w, input bit inject,
                           input logic [31:0] extra);
        logic [4:0]  r;
        logic        wr;
        logic [15:0] d;
        logic [31:0] expw;
        int          n;
        bit          flipped;
        r  = w[20:16];
        wr = w[31];
        d  = wr ? w[15:0] : shadow[r];
        exp_q.push_back('{wr: wr, regn: r, data: d});
        if (wr) shadow[r] = w[15:0];
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = w;
        @(negedge clk);
        cmd_we = 1'b0;
        check(cmd_rdata == w, wr ? "R3" : "R4", "busy readback", cmd_rdata, w);
        n = 0; flipped = 0;
        for (int c = 1; c <= LIMIT + 10; c++) begin
            @(negedge clk);
            if (inject && c == 40) begin
                cmd_we = 1'b1; cmd_wdata = extra;
            end else begin
                cmd_we = 1'b0;
            end
            if (inject && c == 41)
                check(cmd_rdata == w, "R9", "store while busy", cmd_rdata, w);
            if (cmd_rdata[31] != w[31]) begin
                n = c; flipped = 1;
                break;
            end
        end
        check(flipped && n <= LIMIT, "R10", "completion latency", n, LIMIT);
        expw = wr ? {1'b0, w[30:0]} : {1'b1, w[30:16], d};
        check(cmd_rdata == expw, (w[23:21] != 0) ? "R6" : (wr ? "R3" : "R4"),
              "final word", cmd_rdata, expw);
        check(!mdc && !mdio_oe, "R7", "idle pins", {30'h0, mdc, mdio_oe}, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            phy_mem[i] = 16'h0;
            shadow[i]  = 16'h0;
        end
        phy_mem[1] = 16'h796D;
        shadow[1]  = 16'h796D;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cmd_rdata == 32'h0, "R1", "reset word", cmd_rdata, 32'h0);
        check(!mdc && !mdio_oe, "R1", "reset pins", {30'h0, mdc, mdio_oe}, 32'h0);

        run_cmd(32'h8000_1200, 0, 0);
        run_cmd(32'h8004_01E1, 0, 0);
        run_cmd(32'h8009_0200, 0, 0);
        run_cmd(32'h0001_0000, 0, 0);
        run_cmd(32'h0004_0000, 0, 0);
        run_cmd(32'h80E9_ABCD, 0, 0);
        run_cmd(32'h0009_0000, 0, 0);
        run_cmd(32'h8000_1111, 1, 32'h8004_5555);
        run_cmd(32'h0024_0000, 0, 0);
        run_cmd(32'h0000_0000, 0, 0);

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R5", "frames outstanding", exp_q.size(), 0);
        check(oe_bad == 0 && ta_seen > 0, "R8", "read release", oe_bad, 0);
        check(per_bad == 0 && per_seen > 0, "R7", "mdc period", per_bad, 0);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog run did not end actual=%0d expected=%0d", 200000, 0);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

endmodule